// File: doc/BRIEF.md
# Validity-Resolved Triple-Redundant Output Voter

This block sits behind three redundant processor links and turns their per-frame requests into one voted output byte. Each frame, every slice delivers the byte its processor wants to drive, a per-bit mask saying which of those bits the processor vouches for, and a flag saying whether the slice passed its challenge-echo check this frame. Each bit of each slice is resolved on its own. A vouched bit from a slice that passed its check is taken from the processor. Any other bit comes from a fallback bit that the slice itself holds. The three resolved bytes then go through a bitwise two-out-of-three vote.

On the frame-done strobe, the voted byte is registered onto the output port. At the same moment, each slice's fallback copy is loaded with the voted byte, and an agreement byte is registered for each processor. That agreement byte marks the bits where the processor both vouched for its value and matched the vote. The link logic sends it back to that processor during the following frame.

The reset is asynchronous and active-low, with a synchronous release inside the block. Slice `s` occupies bits `[s*W +: W]` of every flattened slice bus. Bit `b` of a slice's byte refers to output bit `b`.

Top module: `tmr_vote_core`

## Requirements
- R1: While reset is asserted, and after its release, `vote_out` and all three agreement bytes in `agree_out` read 0. Every slice fallback also starts at 0, so a frame in which no bit is effectively valid produces `vote_out` = 0x00.
- R2: When mask bit `b` of slice `s` is 1 and `echo_ok[s]` is 1, slice `s` resolves bit `b` to `cpu_want[s*W+b]`.
- R3: When a slice's bit is not effectively valid, the slice resolves that bit to its own stored fallback bit. If no bit of any slice is effectively valid in a frame, `vote_out` does not change.
- R4: When `echo_ok[s]` is 0, every bit of slice `s` is treated as invalid for that frame, and its agreement byte for that frame is 0x00.
- R5: `vote_out` bit `b` is 1 exactly when at least two of the three resolved bits `b` are 1.
- R6: Agreement bit `b` of slice `s` is 1 only when that slice's bit was effectively valid and its requested value equals the newly voted bit `b`. Otherwise it is 0.
- R7: `vote_out` and `agree_out` change only on a clock edge at which `frame_done` is 1. Input changes at any other time have no effect on them.
- R8: At each frame-done strobe, each slice loads its fallback byte with the newly voted byte. A later frame's invalid bits therefore carry the most recent vote.
- R9: Results of a frame appear on `vote_out` and `agree_out` right after the clock edge that samples `frame_done`. They are based on the inputs present at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: a frame's slice data is complete |
| cpu_want | input | 3*W | Requested output byte per slice, slice s at [s*W +: W] |
| cpu_mask | input | 3*W | Per-bit validity mask per slice, 1 = vouched |
| echo_ok | input | 3 | Per-slice challenge-echo pass flag for this frame |
| vote_out | output | W | Registered voted output byte |
| agree_out | output | 3*W | Registered agreement byte per slice, slice s at [s*W +: W] |

## Verification
Both the voted byte and the agreement bytes are due exactly one register stage after the clock edge that samples `frame_done`. The inputs are driven at a falling edge, with the strobe held for one cycle, and the outputs are compared at the next falling edge against a bench model that holds its own fallback copy. Between strobes the inputs are scrambled over several cycles, and the outputs are checked again to confirm that nothing moved. Reset values are checked while reset is asserted and again after the synchronous release has settled.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

  localparam int unsigned NSLICE = 3;

  // Bitwise two-out-of-three majority over three equal-width words
  function automatic logic [63:0] maj3(input logic [63:0] a,
                                       input logic [63:0] b,
                                       input logic [63:0] c);
    maj3 = (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/tmr_slice_resolve.sv
module tmr_slice_resolve #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [W-1:0] want,
  input  logic [W-1:0] mask,
  input  logic         link_ok,
  input  logic [W-1:0] vote_nxt,
  output logic [W-1:0] resolved,
  output logic [W-1:0] eff_mask
);

  logic [W-1:0] fb_q;
  logic [W-1:0] fb_d;

  // A failed echo voids every bit of this slice for the frame
  always_comb begin
    eff_mask = link_ok ? mask : '0;
  end

  // Vouched bits come from the processor, the rest from local fallback
  always_comb begin
    resolved = (eff_mask & want) | (~eff_mask & fb_q);
  end

  // Fallback tracks the last vote; enable written out
  always_comb begin
    fb_d = fb_q;
    if (upd_en) begin
      fb_d = vote_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q <= '0;
    end else begin
      fb_q <= fb_d;
    end
  end

endmodule

// File: rtl/tmr_majority_vote.sv
module tmr_majority_vote
  import tmr_vote_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [NSLICE*W-1:0] res_bus,
  output logic [W-1:0]        vote
);

  logic [63:0] r0, r1, r2, m;

  always_comb begin
    r0 = '0;
    r1 = '0;
    r2 = '0;
    r0[W-1:0] = res_bus[0*W +: W];
    r1[W-1:0] = res_bus[1*W +: W];
    r2[W-1:0] = res_bus[2*W +: W];
    m = maj3(r0, r1, r2);
    vote = m[W-1:0];
  end

endmodule

// File: rtl/tmr_agree_gen.sv
module tmr_agree_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [W-1:0] want,
  input  logic [W-1:0] eff_mask,
  input  logic [W-1:0] vote_nxt,
  output logic [W-1:0] agree_q
);

  logic [W-1:0] agree_d;

  always_comb begin
    agree_d = agree_q;
    if (upd_en) begin
      agree_d = eff_mask & ~(want ^ vote_nxt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agree_q <= '0;
    end else begin
      agree_q <= agree_d;
    end
  end

endmodule

// File: rtl/tmr_vote_core.sv
module tmr_vote_core
  import tmr_vote_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              frame_done,
  input  logic [3*W-1:0]    cpu_want,
  input  logic [3*W-1:0]    cpu_mask,
  input  logic [2:0]        echo_ok,
  output logic [W-1:0]      vote_out,
  output logic [3*W-1:0]    agree_out
);

  localparam int unsigned BUSW = NSLICE * W;

  logic            rst_q_n;
  logic [BUSW-1:0] res_bus;
  logic [BUSW-1:0] eff_bus;
  logic [W-1:0]    vote_nxt;
  logic [W-1:0]    vote_q;
  logic [W-1:0]    vote_d;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    tmr_slice_resolve #(.W(W)) u_res (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .upd_en   (frame_done),
      .want     (cpu_want[s*W +: W]),
      .mask     (cpu_mask[s*W +: W]),
      .link_ok  (echo_ok[s]),
      .vote_nxt (vote_nxt),
      .resolved (res_bus[s*W +: W]),
      .eff_mask (eff_bus[s*W +: W])
    );

    tmr_agree_gen #(.W(W)) u_agr (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .upd_en   (frame_done),
      .want     (cpu_want[s*W +: W]),
      .eff_mask (eff_bus[s*W +: W]),
      .vote_nxt (vote_nxt),
      .agree_q  (agree_out[s*W +: W])
    );
  end

  tmr_majority_vote #(.W(W)) u_vote (
    .res_bus (res_bus),
    .vote    (vote_nxt)
  );

  always_comb begin
    vote_d = vote_q;
    if (frame_done) begin
      vote_d = vote_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vote_q <= '0;
    end else begin
      vote_q <= vote_d;
    end
  end

  assign vote_out = vote_q;

endmodule

// File: rtl/tmr_vote_check.sv
module tmr_vote_check #(
  parameter int unsigned W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_done,
  input logic [3*W-1:0] cpu_want,
  input logic [3*W-1:0] cpu_mask,
  input logic [2:0]     echo_ok,
  input logic [W-1:0]   vote_out,
  input logic [3*W-1:0] agree_out
);

  logic [W-1:0] any_eff;
  always_comb begin
    any_eff = (echo_ok[0] ? cpu_mask[0*W +: W] : '0)
            | (echo_ok[1] ? cpu_mask[1*W +: W] : '0)
            | (echo_ok[2] ? cpu_mask[2*W +: W] : '0);
  end

  // R7: outputs hold between strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(vote_out) && $stable(agree_out)));

  // R3: with no effective valid bit anywhere the vote repeats itself
  a_r3_all_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && any_eff == '0) |=> $stable(vote_out));

  // R5: unanimous fully valid request wins
  a_r5_unanimous: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && echo_ok == 3'b111 && cpu_mask == '1
     && cpu_want[0*W +: W] == cpu_want[1*W +: W]
     && cpu_want[1*W +: W] == cpu_want[2*W +: W])
    |=> vote_out == $past(cpu_want[0*W +: W]));

  for (genvar s = 0; s < 3; s++) begin : g_chk
    // R4: failed echo gives an all-zero agreement byte
    a_r4_fail_no_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !echo_ok[s]) |=> agree_out[s*W +: W] == '0);

    // R6: an agreement bit implies the request matched the vote
    a_r6_agree_matches: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> ((agree_out[s*W +: W]
                       & ($past(cpu_want[s*W +: W]) ^ vote_out)) == '0));

    // R6: an agreement bit implies the bit was vouched
    a_r6_agree_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> ((agree_out[s*W +: W]
                       & ~$past(cpu_mask[s*W +: W])) == '0));
  end

endmodule

bind tmr_vote_core tmr_vote_check #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .frame_done (frame_done),
  .cpu_want   (cpu_want),
  .cpu_mask   (cpu_mask),
  .echo_ok    (echo_ok),
  .vote_out   (vote_out),
  .agree_out  (agree_out)
);

// File: tb/tmr_vote_core_test.sv
`timescale 1ns/1ps
module tmr_vote_core_test;

  localparam int W = 8;
  localparam real HALF = 2.5;

  logic           clk = 1'b0;
  logic           arst_n;
  logic           frame_done;
  logic [3*W-1:0] cpu_want;
  logic [3*W-1:0] cpu_mask;
  logic [2:0]     echo_ok;
  logic [W-1:0]   vote_out;
  logic [3*W-1:0] agree_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [W-1:0]   m_fb [3];
  logic [W-1:0]   m_vote;
  logic [3*W-1:0] m_agree;

  always #(HALF) clk = ~clk;

  tmr_vote_core #(.W(W)) uut (
    .clk(clk), .arst_n(arst_n), .frame_done(frame_done),
    .cpu_want(cpu_want), .cpu_mask(cpu_mask), .echo_ok(echo_ok),
    .vote_out(vote_out), .agree_out(agree_out)
  );

  function automatic logic [W-1:0] maj(input logic [W-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({24'd0, vote_out}, {24'd0, m_vote}, req);
    for (int s = 0; s < 3; s++)
      check({24'd0, agree_out[s*W +: W]}, {24'd0, m_agree[s*W +: W]}, req);
  endtask

  // One frame: drive at falling edge, strobe one cycle, compare after the edge
  task automatic frame(input logic [3*W-1:0] w, input logic [3*W-1:0] m,
                       input logic [2:0] ok, input string req);
    logic [W-1:0] eff [3];
    logic [W-1:0] res [3];
    @(negedge clk);
    cpu_want = w; cpu_mask = m; echo_ok = ok; frame_done = 1'b1;
    for (int s = 0; s < 3; s++) begin
      eff[s] = ok[s] ? m[s*W +: W] : '0;
      res[s] = (eff[s] & w[s*W +: W]) | (~eff[s] & m_fb[s]);
    end
    m_vote = maj(res[0], res[1], res[2]);
    for (int s = 0; s < 3; s++) begin
      m_agree[s*W +: W] = eff[s] & ~(w[s*W +: W] ^ m_vote);
      m_fb[s] = m_vote;
    end
    @(negedge clk);
    frame_done = 1'b0;
    check_all(req);
  endtask

  // Scramble inputs without a strobe; outputs must hold (R7)
  task automatic idle_scramble(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      cpu_want = {$urandom, $urandom} ;
      cpu_mask = $urandom;
      echo_ok = $urandom;
    end
    @(negedge clk);
    check_all("R7");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    arst_n = 1'b0; frame_done = 1'b0;
    cpu_want = '0; cpu_mask = '0; echo_ok = '0;
    for (int s = 0; s < 3; s++) m_fb[s] = '0;
    m_vote = '0; m_agree = '0;
    repeat (3) @(negedge clk);
    check_all("R1");
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R1: fallbacks start at zero
    frame({24'hFFFFFF}, 24'h0, 3'b111, "R1");
    // R2 R5: all valid, two agree against one
    frame({8'h0F, 8'hA5, 8'hA5}, 24'hFFFFFF, 3'b111, "R2_R5");
    // R6: slice 2 disagrees on some bits
    frame({8'h3C, 8'h5A, 8'h5A}, 24'hFFFFFF, 3'b111, "R6");
    // R3 R8: nothing valid, vote carried from last frame
    frame({8'hFF, 8'h00, 8'hFF}, 24'h000000, 3'b111, "R3_R8");
    // R8: single valid slice outvoted by two fallbacks
    frame({8'h00, 8'h00, 8'hFF}, {8'h00, 8'h00, 8'hFF}, 3'b111, "R8");
    // R4: failed echo voids a fully vouched slice
    frame({8'hC3, 8'hC3, 8'h3C}, 24'hFFFFFF, 3'b011, "R4");
    frame({8'h11, 8'h22, 8'h44}, 24'hFFFFFF, 3'b000, "R4_R3");
    // R5: mixed masks, bitwise vote
    frame({8'hF0, 8'hCC, 8'hAA}, {8'hFF, 8'h0F, 8'hF0}, 3'b111, "R5");
    idle_scramble(5);

    for (int i = 0; i < 300; i++) begin
      frame({$urandom, $urandom}, {$urandom, $urandom}, 3'($urandom), "R9_R2_R6");
      if ((i % 25) == 0) idle_scramble(3);
    end

    // R1: reset mid-run clears outputs and fallbacks
    @(negedge clk);
    arst_n = 1'b0;
    for (int s = 0; s < 3; s++) m_fb[s] = '0;
    m_vote = '0; m_agree = '0;
    @(negedge clk);
    check_all("R1");
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    frame(24'hFFFFFF, 24'h0, 3'b111, "R1");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(2.0 * HALF * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule